// File: doc/BRIEF.md
# Guarded byte-store access controller

This block sits on a CPU's register bus and gives software byte-wide access to a 512-entry data store. The store is its own address space and is not mapped into memory. Three things are visible to software: an address, split across a low and a high byte register, a data register, and a command/status register. To read a byte, software selects an address and sets the read command bit. The CPU is then stalled for a fixed time while the data register is filled from the store.

A write needs two steps. Software first writes the command register with the arm bit set and the strobe bit clear. It must then set the strobe bit within a short window, or the arm state lapses. A write that is accepted stalls the CPU briefly and then runs for a programmable number of cycles. During that time the strobe bit reads back as one, so software can poll it. When the write completes, a one-cycle ready pulse is raised. A strobe is refused while an external flash self-programming flag is high. The address and data registers are frozen while a write runs.

Top module: `gsc_top`

## Requirements
- R1: After reset the address bytes, the data register and the command register all read 0x00, and `cpuStall` and `readyIrq` are low.
- R2: Register select 0 is the address low byte and register select 1 is the address high byte. Only bit 0 of the high byte is stored, and bits 7:1 of the high byte always read as zero.
- R3: Register select 3 is the command register. Writing it with bit 0 set (read command) while no write is busy raises `cpuStall` for exactly 4 cycles. After that, register select 2 (data) holds the byte at the current address, and bit 0 reads 0.
- R4: Writing the command register with bit 2 set and bit 1 clear arms the block. Writing bit 1 (strobe) 1 to 4 cycles after the arming write starts a write and raises `cpuStall` for exactly 2 cycles.
- R5: A strobe written 5 or more cycles after arming starts no write, and the store is unchanged. Bit 2 of the command register reads 0 once the window has lapsed.
- R6: After an accepted strobe, bit 1 of the command register reads 1 for exactly WRITE_CYCLES cycles (64 by default) and then 0. The store then holds, at the address register's value, the data register's value as they stood when the strobe fired.
- R7: While `flashBusy` is high, a strobe starts no write and no stall, and the store is unchanged.
- R8: `readyIrq` is high for exactly one cycle, in the first cycle in which bit 1 of the command register reads 0 after a write.
- R9: While a write is busy, bus writes to the address and data registers do not change them, and a read command is ignored: no stall occurs.
- R10: A strobe written while the block is not armed, including a single write that sets both bit 2 and bit 1, starts no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe from the CPU |
| busAddr | input | 2 | Register select: 0 address low, 1 address high, 2 data, 3 command |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Combinational read-back of the selected register |
| flashBusy | input | 1 | Flash self-programming active; blocks write starts |
| cpuStall | output | 1 | Holds the CPU while a read or a write start completes |
| readyIrq | output | 1 | One-cycle pulse when a write finishes |

## Verification
Several properties are checked on every cycle:
- the arm state never outlives its four-cycle window;
- the busy phase never exceeds WRITE_CYCLES;
- an accepted read command always raises a stall;
- an armed strobe always starts a write, and none starts while `flashBusy` is high;
- the ready pulse lasts one cycle and coincides with the end of busy;
- the address and data registers stay frozen while a write runs.

Other behaviours can only be shown by the bench's scenarios. These are that the right byte lands at the right address, that a late or unarmed strobe leaves the store untouched, and the exact stall lengths. The bench reads values back through the data register to show them.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  localparam int DATA_W = 8;

  localparam logic [1:0] SEL_ADDR_LO = 2'd0;
  localparam logic [1:0] SEL_ADDR_HI = 2'd1;
  localparam logic [1:0] SEL_DATA    = 2'd2;
  localparam logic [1:0] SEL_CMD     = 2'd3;

  localparam int BIT_READ   = 0;
  localparam int BIT_STROBE = 1;
  localparam int BIT_ARM    = 2;

  typedef struct packed {
    logic              ldAddrLo;
    logic              ldAddrHi;
    logic              ldData;
    logic              ldRead;
    logic              commit;
    logic [DATA_W-1:0] wrData;
  } dpStrobe_t;
endpackage

// File: rtl/gsc_ctrl.sv
module gsc_ctrl
  import gsc_pkg::*;
#(
  parameter int WRITE_CYCLES = 64,
  parameter int ARM_WINDOW   = 4,
  parameter int RD_STALL     = 4,
  parameter int WR_STALL     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              flashBusy,
  output dpStrobe_t         strobe,
  output logic              cpuStall,
  output logic              readyIrq,
  output logic              armFlag,
  output logic              busyFlag,
  output logic              readPend
);
  localparam int ARM_CW   = $clog2(ARM_WINDOW + 1);
  localparam int BUSY_CW  = $clog2(WRITE_CYCLES + 1);
  localparam int STALL_MX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int STALL_CW = $clog2(STALL_MX + 1);

  localparam logic [ARM_CW-1:0]   ARM_LOAD  = ARM_CW'(ARM_WINDOW);
  localparam logic [BUSY_CW-1:0]  BUSY_LOAD = BUSY_CW'(WRITE_CYCLES);
  localparam logic [BUSY_CW-1:0]  BUSY_ONE  = BUSY_CW'(1);
  localparam logic [STALL_CW-1:0] RD_LOAD   = STALL_CW'(RD_STALL);
  localparam logic [STALL_CW-1:0] WR_LOAD   = STALL_CW'(WR_STALL);
  localparam logic [STALL_CW-1:0] STALL_ONE = STALL_CW'(1);

  logic [ARM_CW-1:0]   armCnt;
  logic [BUSY_CW-1:0]  busyCnt;
  logic [STALL_CW-1:0] stallCnt;

  logic accept, cmdWr, wantRead, wantArm, fire;

  assign armFlag  = (armCnt != '0);
  assign busyFlag = (busyCnt != '0);
  assign cpuStall = (stallCnt != '0);

  // Bus writes are refused while the CPU is held.
  assign accept   = busWrEn && !cpuStall;
  assign cmdWr    = accept && (busAddr == SEL_CMD);
  assign wantRead = cmdWr && busWrData[BIT_READ] && !busyFlag;
  assign wantArm  = cmdWr && busWrData[BIT_ARM] && !busWrData[BIT_STROBE]
                    && !busWrData[BIT_READ] && !busyFlag;
  assign fire     = cmdWr && busWrData[BIT_STROBE] && !busWrData[BIT_READ]
                    && armFlag && !busyFlag && !flashBusy;

  // Arm window: loaded on arming, counts down, consumed by a fire.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                armCnt <= '0;
    else if (fire)            armCnt <= '0;
    else if (wantArm)         armCnt <= ARM_LOAD;
    else if (armCnt != '0)    armCnt <= armCnt - 1'b1;
  end

  // Self-timed write duration.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busyCnt <= '0;
    else if (fire)            busyCnt <= BUSY_LOAD;
    else if (busyCnt != '0)   busyCnt <= busyCnt - 1'b1;
  end

  // CPU hold timer shared by read and write starts.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                stallCnt <= '0;
    else if (wantRead)        stallCnt <= RD_LOAD;
    else if (fire)            stallCnt <= WR_LOAD;
    else if (stallCnt != '0)  stallCnt <= stallCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     readPend <= 1'b0;
    else if (wantRead)                             readPend <= 1'b1;
    else if (readPend && (stallCnt == STALL_ONE))  readPend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readyIrq <= 1'b0;
    else       readyIrq <= (busyCnt == BUSY_ONE);
  end

  always_comb begin
    strobe          = '0;
    strobe.wrData   = busWrData;
    strobe.ldAddrLo = accept && !busyFlag && (busAddr == SEL_ADDR_LO);
    strobe.ldAddrHi = accept && !busyFlag && (busAddr == SEL_ADDR_HI);
    strobe.ldData   = accept && !busyFlag && (busAddr == SEL_DATA);
    strobe.ldRead   = readPend && (stallCnt == STALL_ONE);
    strobe.commit   = (busyCnt == BUSY_ONE);
  end
endmodule

// File: rtl/gsc_datapath.sv
module gsc_datapath
  import gsc_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] addrLoView,
  output logic [DATA_W-1:0] addrHiView,
  output logic [DATA_W-1:0] dataView
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrReg <= '0;
    else begin
      if (strobe.ldAddrLo) addrReg[DATA_W-1:0] <= strobe.wrData;
      if (strobe.ldAddrHi) addrReg[ADDR_W-1:DATA_W] <= strobe.wrData[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataReg <= '0;
    else if (strobe.ldRead) dataReg <= store[addrReg];
    else if (strobe.ldData) dataReg <= strobe.wrData;
  end

  always_ff @(posedge clk) begin
    if (strobe.commit) store[addrReg] <= dataReg;
  end

  assign addrLoView = addrReg[DATA_W-1:0];
  assign addrHiView = DATA_W'(addrReg[ADDR_W-1:DATA_W]);
  assign dataView   = dataReg;
endmodule

// File: rtl/gsc_top.sv
module gsc_top
  import gsc_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int WRITE_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [1:0]  busAddr,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  input  logic        flashBusy,
  output logic        cpuStall,
  output logic        readyIrq
);
  dpStrobe_t         strobe;
  logic              armFlag, busyFlag, readPend;
  logic [DATA_W-1:0] addrLoView, addrHiView, dataView;

  gsc_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .flashBusy(flashBusy), .strobe(strobe),
    .cpuStall(cpuStall), .readyIrq(readyIrq), .armFlag(armFlag),
    .busyFlag(busyFlag), .readPend(readPend)
  );

  gsc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrLoView(addrLoView),
    .addrHiView(addrHiView), .dataView(dataView)
  );

  always_comb begin
    unique case (busAddr)
      SEL_ADDR_LO: busRdData = addrLoView;
      SEL_ADDR_HI: busRdData = addrHiView;
      SEL_DATA:    busRdData = dataView;
      default:     busRdData = {5'b0, armFlag, busyFlag, readPend};
    endcase
  end
endmodule

// File: rtl/gsc_checker.sv
module gsc_checker #(
  parameter int WRITE_CYCLES = 64,
  parameter int ARM_WINDOW   = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       busWrEn,
  input logic [1:0] busAddr,
  input logic [7:0] busWrData,
  input logic       flashBusy,
  input logic       cpuStall,
  input logic       readyIrq,
  input logic       armFlag,
  input logic       busyFlag,
  input logic [7:0] addrLoView,
  input logic [7:0] dataView
);
  logic [7:0]  armAge;
  logic [15:0] busyAge;
  logic        cmdWrite;

  assign cmdWrite = busWrEn && !cpuStall && (busAddr == 2'd3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armAge  <= '0;
      busyAge <= '0;
    end else begin
      armAge  <= armFlag  ? armAge + 1'b1  : '0;
      busyAge <= busyFlag ? busyAge + 1'b1 : '0;
    end
  end

  assert_arm_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    armFlag |-> (armAge < 8'(ARM_WINDOW)));

  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rstN)
    busyFlag |-> (busyAge < 16'(WRITE_CYCLES)));

  assert_read_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && busWrData[0] && !busyFlag) |=> cpuStall);

  assert_armed_fire_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && busWrData[1] && !busWrData[0] && armFlag && !busyFlag && !flashBusy)
      |=> (busyFlag && cpuStall));

  assert_flash_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flashBusy && !busyFlag) |=> !busyFlag);

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    readyIrq |=> !readyIrq);

  assert_irq_at_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyFlag) |-> readyIrq);

  assert_regs_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busyFlag && $past(busyFlag)) |-> ($stable(addrLoView) && $stable(dataView)));

  assert_busy_read_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busyFlag && !cpuStall) |=> !cpuStall);
endmodule

bind gsc_top gsc_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_gsc_checker (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .flashBusy(flashBusy), .cpuStall(cpuStall),
  .readyIrq(readyIrq), .armFlag(armFlag), .busyFlag(busyFlag),
  .addrLoView(addrLoView), .dataView(dataView)
);

// File: tb/test_gsc_top.sv
module test_gsc_top;
  localparam int CLK_PERIOD = 10;
  localparam int WCYC = 64;

  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_DATA = 2'd2, A_CMD = 2'd3;

  // Each entry: {address[8:0], data[7:0]}
  localparam logic [16:0] VEC [4] = '{
    {9'h000, 8'hA5}, {9'h1FF, 8'h3C}, {9'h100, 8'h01}, {9'h0FF, 8'hFE}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic       flashBusy = 1'b0;
  logic       cpuStall, readyIrq;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gsc_top #(.WRITE_CYCLES(WCYC)) i_gsc_top (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .flashBusy(flashBusy),
    .cpuStall(cpuStall), .readyIrq(readyIrq)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  task automatic setAddr(input logic [8:0] a);
    wr(A_LO, a[7:0]);
    wr(A_HI, {7'd0, a[8]});
  endtask

  // Arm, wait gap idle cycles, strobe; measure stall and busy lengths.
  task automatic doWrite(input logic [8:0] a, input logic [7:0] d, input int gap,
                         output int stallN, output int busyN, output logic irqAtEnd);
    logic [7:0] st;
    setAddr(a);
    wr(A_DATA, d);
    wr(A_CMD, 8'h04);
    repeat (gap) @(negedge clk);
    wr(A_CMD, 8'h02);
    stallN = 0; busyN = 0;
    rd(A_CMD, st);
    while (st[1] && busyN < 500) begin
      if (cpuStall) stallN++;
      busyN++;
      @(negedge clk);
      rd(A_CMD, st);
    end
    irqAtEnd = readyIrq;
  endtask

  task automatic doRead(input logic [8:0] a, output logic [7:0] v, output int stallN);
    setAddr(a);
    wr(A_CMD, 8'h01);
    stallN = 0;
    while (cpuStall && stallN < 20) begin
      stallN++;
      @(negedge clk);
    end
    rd(A_DATA, v);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    int sN, bN;
    logic irq;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_LO, v);   check("R1 addr lo", v, 0);
    rd(A_HI, v);   check("R1 addr hi", v, 0);
    rd(A_DATA, v); check("R1 data", v, 0);
    rd(A_CMD, v);  check("R1 cmd", v, 0);
    check("R1 stall", cpuStall, 0);
    check("R1 irq", readyIrq, 0);

    // Table walk: write each vector with varying arm gaps (R4, R6, R8)
    for (int i = 0; i < 4; i++) begin
      doWrite(VEC[i][16:8], VEC[i][7:0], i, sN, bN, irq);
      check("R4 write stall length", sN, 2);
      check("R6 busy length", bN, WCYC);
      check("R8 irq at busy end", irq, 1);
      @(negedge clk);
      check("R8 irq single cycle", readyIrq, 0);
    end
    // R2 high byte written 0xFF holds only bit 0
    wr(A_HI, 8'hFF);
    rd(A_HI, v); check("R2 addr hi masked", v, 8'h01);
    // R3/R6 read back every vector
    for (int i = 0; i < 4; i++) begin
      doRead(VEC[i][16:8], v, sN);
      check("R3 read stall length", sN, 4);
      check("R6 stored byte", v, VEC[i][7:0]);
      rd(A_CMD, v); check("R3 read bit cleared", v[0], 0);
    end

    // R4 boundary: strobe 3 idle cycles after arming (4th cycle) is accepted
    doWrite(9'h055, 8'hC3, 3, sN, bN, irq);
    check("R4 gap 3 accepted", bN, WCYC);
    doRead(9'h055, v, sN); check("R4 gap 3 data", v, 8'hC3);

    // R5 strobe 4 idle cycles after arming (5th cycle) rejected
    setAddr(9'h0FF);
    wr(A_DATA, 8'h77);
    wr(A_CMD, 8'h04);
    repeat (4) @(negedge clk);
    rd(A_CMD, v); check("R5 arm lapsed", v[2], 0);
    wr(A_CMD, 8'h02);
    check("R5 no stall", cpuStall, 0);
    rd(A_CMD, v); check("R5 not busy", v[1], 0);
    doRead(9'h0FF, v, sN); check("R5 store unchanged", v, 8'hFE);

    // R7 flash programming blocks the strobe
    flashBusy = 1'b1;
    setAddr(9'h000);
    wr(A_DATA, 8'h11);
    wr(A_CMD, 8'h04);
    wr(A_CMD, 8'h02);
    check("R7 no stall", cpuStall, 0);
    rd(A_CMD, v); check("R7 not busy", v[1], 0);
    flashBusy = 1'b0;
    repeat (6) @(negedge clk);
    doRead(9'h000, v, sN); check("R7 store unchanged", v, 8'hA5);

    // R10 strobe without arming, including combined arm+strobe write
    setAddr(9'h100);
    wr(A_DATA, 8'h99);
    wr(A_CMD, 8'h06);
    rd(A_CMD, v); check("R10 combined write not busy", v[1], 0);
    wr(A_CMD, 8'h02);
    rd(A_CMD, v); check("R10 bare strobe not busy", v[1], 0);
    doRead(9'h100, v, sN); check("R10 store unchanged", v, 8'h01);

    // R9 register freeze and read ignore during busy
    setAddr(9'h001);
    wr(A_DATA, 8'h5A);
    wr(A_CMD, 8'h04);
    wr(A_CMD, 8'h02);
    repeat (3) @(negedge clk);
    wr(A_LO, 8'h02);
    wr(A_DATA, 8'h99);
    wr(A_CMD, 8'h01);
    check("R9 read ignored no stall", cpuStall, 0);
    rd(A_LO, v);   check("R9 addr frozen", v, 8'h01);
    rd(A_DATA, v); check("R9 data frozen", v, 8'h5A);
    rd(A_CMD, v);  check("R9 still busy", v[1], 1);
    repeat (WCYC + 2) @(negedge clk);
    doRead(9'h001, v, sN); check("R9 written byte", v, 8'h5A);

    finishRun();
  end
endmodule